// File: doc/BRIEF.md
# Selectable Edge/Level Interrupt Request Latch

This block keeps the pending-request state for a bank of interrupt lines, eight by default. Each line is sensed as either an edge or a level source, chosen by one bit of a trigger-mode register. For a level line, the pending bit copies the sampled input. For an edge line, the pending bit is set when the input is high and the stored previous level was low. It then stays set until the acknowledge logic clears it. The previous level of every line is refreshed on every clock, whatever the line's mode.

A separate per-line mask input hides lines from the downstream priority logic. A masked line still latches its pending bit, but it is left out of the registered candidate vector. The acknowledge strobe names one line by index. It clears that line's pending bit only when the line is in edge mode. Software writes the trigger-mode register with a full data word. The register keeps only the bits allowed by a per-instance writable mask, so lines whose mode must stay fixed remain in edge mode.

Top module: `irq_req_latch`

## Requirements
- R1: A line in level mode (trigger-mode bit = 1) has its pending bit equal to the input value sampled at the previous clock edge. It sets while the input is high and clears once the input is low.
- R2: A line in edge mode (trigger-mode bit = 0) sets its pending bit at the edge where the input is 1 and the stored previous level is 0. A later low input does not clear the bit.
- R3: The stored previous level of every line takes the sampled input at every clock edge in both modes. An edge line that switched from level mode while its input was high is therefore not set again after an acknowledge while the input stays high.
- R4: An acknowledge (ack_en = 1, ack_idx = line number) clears the pending bit of an edge-mode line at that clock edge. It leaves a level-mode line's pending bit unchanged.
- R5: A trigger-mode write (trig_we = 1) loads trig_wdata AND WR_MASK (default 8'hF8) into the register. The new value is visible on trig_mode_o after that edge and is used for sensing from the following edge on.
- R6: A masked line (irq_mask bit = 1) still latches its pending bit on pend_o, and its cand_o bit is 0 one edge later.
- R7: cand_o is pend_o AND NOT irq_mask, registered one clock edge after pend_o.
- R8: Reset (rst_n = 0) clears the pending bits, the previous-level bits, the trigger-mode register (all lines edge mode) and cand_o. An input that is high when reset is released is therefore seen as a rising edge.
- R9: When a new rising edge and an acknowledge hit the same edge-mode line at the same edge, the line ends up pending.
- R10: An acknowledge affects only the line named by ack_idx. Other pending bits keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_lines | input | NUM_LINES | Sampled interrupt input levels |
| irq_mask | input | NUM_LINES | Per-line mask; 1 hides the line from cand_o |
| ack_en | input | 1 | Acknowledge strobe |
| ack_idx | input | IDX_W | Line number being acknowledged |
| trig_we | input | 1 | Trigger-mode register write strobe |
| trig_wdata | input | NUM_LINES | Trigger-mode write data (1 = level, 0 = edge) |
| pend_o | output | NUM_LINES | Pending-request bits |
| cand_o | output | NUM_LINES | Registered unmasked pending requests |
| trig_mode_o | output | NUM_LINES | Current trigger-mode register |

## Verification
Inputs, acknowledges and mode writes take effect at the next rising edge. pend_o and trig_mode_o are due one edge after the stimulus, and cand_o is due one edge after that. The bench drives on the falling edge, advances one full cycle per step and samples on the following falling edge. It checks pend_o after one step and cand_o after two, so each sample lands exactly in the cycle the requirement names. A mode write needs one step before a sensing change can be seen, and the scenarios that switch modes account for that extra step.

// File: rtl/irql_pkg.sv
package irql_pkg;

    typedef enum logic {
        TRIG_EDGE  = 1'b0,
        TRIG_LEVEL = 1'b1
    } trig_mode_e;

    typedef struct packed {
        logic pend;
        logic prev;
    } line_state_t;

endpackage

// File: rtl/irql_line_cell.sv
module irql_line_cell
    import irql_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic irq_i,
    input  logic mode_i,
    input  logic ack_i,
    output logic pend_o
);

    line_state_t st_d, st_q;
    trig_mode_e  mode_e;
    logic        rise;

    assign mode_e = trig_mode_e'(mode_i);

    always_comb begin
        st_d      = st_q;
        rise      = irq_i & ~st_q.prev;
        st_d.prev = irq_i;
        if (mode_e == TRIG_LEVEL) begin
            st_d.pend = irq_i;
        end else begin
            if (ack_i) begin
                st_d.pend = 1'b0;
            end
            if (rise) begin
                st_d.pend = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_o = st_q.pend;

    AST_LEVEL_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        mode_i |=> (pend_o == $past(irq_i)));                                // R1
    AST_EDGE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_i && irq_i && !st_q.prev) |=> pend_o);                         // R2
    AST_EDGE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_i && pend_o && !ack_i) |=> pend_o);                            // R10
    AST_PREV_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (st_q.prev == $past(irq_i)));                                // R3
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_i && ack_i && !(irq_i && !st_q.prev)) |=> !pend_o);            // R4
    AST_RISE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_i && ack_i && irq_i && !st_q.prev) |=> pend_o);                // R9

endmodule

// File: rtl/irql_mode_reg.sv
module irql_mode_reg #(
    parameter int unsigned        NUM_LINES = 8,
    parameter logic [NUM_LINES-1:0] WR_MASK = 8'hF8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we_i,
    input  logic [NUM_LINES-1:0] wdata_i,
    output logic [NUM_LINES-1:0] mode_o
);

    typedef struct packed {
        logic [NUM_LINES-1:0] mode;
    } mode_state_t;

    mode_state_t ms_d, ms_q;

    always_comb begin
        ms_d = ms_q;
        if (we_i) begin
            ms_d.mode = wdata_i & WR_MASK;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ms_q <= '0;
        end else begin
            ms_q <= ms_d;
        end
    end

    assign mode_o = ms_q.mode;

    AST_MODE_WRMASK: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> (mode_o == ($past(wdata_i) & WR_MASK)));                      // R5
    AST_MODE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |=> $stable(mode_o));                                            // R5

endmodule

// File: rtl/irql_cand_reg.sv
module irql_cand_reg #(
    parameter int unsigned NUM_LINES = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] pend_i,
    input  logic [NUM_LINES-1:0] mask_i,
    output logic [NUM_LINES-1:0] cand_o
);

    typedef struct packed {
        logic [NUM_LINES-1:0] cand;
    } cand_state_t;

    cand_state_t cs_d, cs_q;

    always_comb begin
        cs_d      = cs_q;
        cs_d.cand = pend_i & ~mask_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_q <= '0;
        end else begin
            cs_q <= cs_d;
        end
    end

    assign cand_o = cs_q.cand;

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_chk
        AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
            mask_i[g] |=> !cand_o[g]);                                         // R6
        AST_CAND_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
            (pend_i[g] && !mask_i[g]) |=> cand_o[g]);                          // R7
    end

endmodule

// File: rtl/irq_req_latch.sv
module irq_req_latch #(
    parameter int unsigned          NUM_LINES = 8,
    parameter logic [NUM_LINES-1:0] WR_MASK   = 8'hF8,
    localparam int unsigned         IDX_W     = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_lines,
    input  logic [NUM_LINES-1:0] irq_mask,
    input  logic                 ack_en,
    input  logic [IDX_W-1:0]     ack_idx,
    input  logic                 trig_we,
    input  logic [NUM_LINES-1:0] trig_wdata,
    output logic [NUM_LINES-1:0] pend_o,
    output logic [NUM_LINES-1:0] cand_o,
    output logic [NUM_LINES-1:0] trig_mode_o
);

    logic [NUM_LINES-1:0] ack_vec;
    logic [NUM_LINES-1:0] mode_w;
    logic [NUM_LINES-1:0] pend_w;

    always_comb begin
        ack_vec = '0;
        for (int i = 0; i < NUM_LINES; i++) begin
            if (ack_en && (ack_idx == IDX_W'(i))) begin
                ack_vec[i] = 1'b1;
            end
        end
    end

    irql_mode_reg #(
        .NUM_LINES (NUM_LINES),
        .WR_MASK   (WR_MASK)
    ) u_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (trig_we),
        .wdata_i (trig_wdata),
        .mode_o  (mode_w)
    );

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        irql_line_cell u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .irq_i  (irq_lines[g]),
            .mode_i (mode_w[g]),
            .ack_i  (ack_vec[g]),
            .pend_o (pend_w[g])
        );
    end

    irql_cand_reg #(
        .NUM_LINES (NUM_LINES)
    ) u_cand (
        .clk    (clk),
        .rst_n  (rst_n),
        .pend_i (pend_w),
        .mask_i (irq_mask),
        .cand_o (cand_o)
    );

    assign pend_o      = pend_w;
    assign trig_mode_o = mode_w;

    AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ack_vec));                                                    // R10
    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |-> (pend_o == '0 && cand_o == '0 && trig_mode_o == '0));       // R8

endmodule

// File: tb/tb_irq_req_latch.sv
module tb_irq_req_latch;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] irq_lines = '0;
    logic [7:0] irq_mask = '0;
    logic       ack_en = 1'b0;
    logic [2:0] ack_idx = '0;
    logic       trig_we = 1'b0;
    logic [7:0] trig_wdata = '0;
    logic [7:0] pend_o, cand_o, trig_mode_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    irq_req_latch dut (
        .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .irq_mask(irq_mask),
        .ack_en(ack_en), .ack_idx(ack_idx), .trig_we(trig_we),
        .trig_wdata(trig_wdata), .pend_o(pend_o), .cand_o(cand_o),
        .trig_mode_o(trig_mode_o)
    );

    task automatic step();
        @(negedge clk);
    endtask

    task automatic chk(string req, string what, logic [7:0] act, logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
        end
    endtask

    task automatic idle();
        ack_en = 1'b0; trig_we = 1'b0;
    endtask

    task automatic write_mode(logic [7:0] v);
        trig_we = 1'b1; trig_wdata = v;
        step();
        trig_we = 1'b0;
    endtask

    task automatic ack(int idx);
        ack_en = 1'b1; ack_idx = 3'(idx);
        step();
        ack_en = 1'b0;
    endtask

    task automatic clear_all();
        idle();
        irq_lines = '0; irq_mask = '0;
        write_mode(8'h00);
        for (int i = 0; i < 8; i++) ack(i);
        step();
    endtask

    task automatic t_reset();
        irq_lines = 8'h10;
        step();
        chk("R8", "pend in reset", pend_o, 8'h00);
        chk("R8", "cand in reset", cand_o, 8'h00);
        chk("R8", "mode in reset", trig_mode_o, 8'h00);
        rst_n = 1'b1;
        step();
        chk("R8", "high input after reset seen as edge", pend_o, 8'h10);
        irq_lines = 8'h00;
        ack(4);
        chk("R8", "pend after ack", pend_o, 8'h00);
    endtask

    task automatic t_edge();
        clear_all();
        irq_lines = 8'h20; step();
        chk("R2", "rise sets pend", pend_o, 8'h20);
        irq_lines = 8'h00; step();
        chk("R2", "fall keeps pend", pend_o, 8'h20);
        ack(5);
        chk("R4", "ack clears edge line", pend_o, 8'h00);
        irq_lines = 8'h20; step();
        ack(5);
        chk("R4", "ack clears while input high", pend_o, 8'h00);
        step();
        chk("R2", "no reset without new rise", pend_o, 8'h00);
    endtask

    task automatic t_mode();
        clear_all();
        write_mode(8'hFF);
        chk("R5", "writable mask applied", trig_mode_o, 8'hF8);
        write_mode(8'h07);
        chk("R5", "fixed bits stay edge", trig_mode_o, 8'h00);
    endtask

    task automatic t_level();
        clear_all();
        write_mode(8'hF8);
        irq_lines = 8'h40; step();
        chk("R1", "level high sets", pend_o, 8'h40);
        ack(6);
        chk("R4", "ack ignored on level line", pend_o, 8'h40);
        irq_lines = 8'h00; step();
        chk("R1", "level low clears", pend_o, 8'h00);
    endtask

    task automatic t_prev();
        clear_all();
        write_mode(8'hF8);
        irq_lines = 8'h08; step();
        chk("R3", "level line pending", pend_o, 8'h08);
        write_mode(8'h00);
        chk("R3", "pend kept across mode switch", pend_o, 8'h08);
        ack(3);
        chk("R3", "ack clears after switch", pend_o, 8'h00);
        step();
        chk("R3", "previous level tracked in level mode", pend_o, 8'h00);
    endtask

    task automatic t_mask();
        clear_all();
        irq_mask = 8'h80;
        irq_lines = 8'h82; step();
        chk("R6", "masked line latches", pend_o, 8'h82);
        chk("R7", "cand one edge behind pend", cand_o, 8'h00);
        step();
        chk("R6", "masked line not a candidate", cand_o, 8'h02);
        irq_mask = 8'h00; step();
        chk("R7", "unmask shows candidate", cand_o, 8'h82);
    endtask

    task automatic t_collide();
        clear_all();
        irq_lines = 8'h04; ack_en = 1'b1; ack_idx = 3'd2;
        step();
        ack_en = 1'b0;
        chk("R9", "rise beats ack", pend_o, 8'h04);
    endtask

    task automatic t_other();
        clear_all();
        irq_lines = 8'h03; step();
        ack(1);
        chk("R10", "only named line cleared", pend_o, 8'h01);
    endtask

    initial begin
        step();
        t_reset();
        t_edge();
        t_mode();
        t_level();
        t_prev();
        t_mask();
        t_collide();
        t_other();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule